// File: doc/BRIEF.md
# Tag Inventory Anticollision and State Controller

This block is the decision core of a read-only vicinity tag that carries a fixed 64-bit identifier. A front end has already demodulated the reader's frame and checked its CRC, and it presents the result as a one-cycle request strobe with the flags byte, command code, mask length, mask bits, received identifier and a CRC-good bit. Separate one-cycle strobes mark a bare end-of-frame (used to step through inventory slots) and a start-of-frame. A level input reports whether the carrier field is present, and a slow free-running tick measures how long the field has been gone.

The controller keeps the tag in one of three states: Ready, Quiet, or Held-Quiet. Held-Quiet is a silenced state that outlives a short field dropout. From these states and the request, the controller decides whether the tag answers. For inventory it runs the slot counter and compares the slot number and the mask against the low identifier bits. When an answer is due, it waits a fixed response delay, restarting the wait on any full-depth pause. It then raises a one-cycle transmit strobe together with a kind bit that tells the encoder which payload to send. An inventory reply is a zero flags byte, a zero format byte and the identifier. A reset reply is the flags byte alone.

Top module: `tag_inventory_ctrl`

## Requirements
- R1: An inventory request (command 0x01, flags bit 2 set) in Ready that matches causes `tx_start` to pulse for exactly one cycle, `RESP_DELAY` cycles after the cycle in which `req_valid` was sampled, with `tx_kind` = 0. Flags bit 5 set selects a single slot.
- R2: With flags bit 5 clear, the slot counter starts at 0 on the request and each `eof_evt` advances it by one, up to slot 15. The tag answers only in the slot whose number equals the 4 identifier bits just above the mask bits. That answer comes `RESP_DELAY` cycles after that `eof_evt`.
- R3: The low `mask_len` bits of `req_mask` must equal the low `mask_len` bits of the identifier, or the tag stays silent in that slot.
- R4: A mask length above 60 with 16 slots, or above 64 with one slot, gets no answer.
- R5: A request gets no answer and leaves the state unchanged when `req_crc_ok` is 0 or when flags bit 3, bit 4 or bit 7 is set.
- R6: Any command code other than 0x01, 0x02, 0x26 and 0xAA gets no answer.
- R7: Command 0x02 with flags bit 5 set (addressed) and a matching `req_uid` moves the tag to Quiet (`tag_state` = 1) with no answer. A non-matching identifier leaves the state unchanged.
- R8: In Quiet or Held-Quiet, requests with flags bit 2 set are ignored.
- R9: Command 0x26 addressed with a matching identifier returns the tag to Ready (`tag_state` = 0) from any state and answers with `tx_kind` = 1. Non-addressed, it answers in Ready, releases Held-Quiet to Ready with an answer, and is ignored in Quiet.
- R10: Command 0xAA, addressed with a matching identifier, moves the tag to Held-Quiet (`tag_state` = 2) with no answer.
- R11: A `pause_full` pulse during the response wait restarts the wait, so `tx_start` follows `RESP_DELAY` cycles after the pause.
- R12: Loss of `field_on` returns Quiet to Ready at once. Held-Quiet survives unless `HOLD_TICKS` ticks of `slow_tick` occur while the field is absent.
- R13: `sof_evt` ends an inventory sequence, so later `eof_evt` strobes bring no answer. An `eof_evt` in the last slot also ends the sequence.
- R14: `tx_start` is never high for two cycles in a row, is only high in Ready, and is never raised in the cycle after `field_on` is low. A field loss cancels a pending answer.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Block clock (one carrier cycle per clock nominally) |
| rst_n | input | 1 | Asynchronous active-low reset |
| field_on | input | 1 | Carrier field present |
| slow_tick | input | 1 | Free-running low-rate tick for the hold timer |
| req_valid | input | 1 | One-cycle strobe: a decoded request has ended |
| req_flags | input | 8 | Request flags byte, bit 0 first transmitted |
| req_cmd | input | 8 | Command code |
| req_mask_len | input | 7 | Inventory mask length in bits |
| req_mask | input | 64 | Mask bits, LSB aligned, zero padded |
| req_uid | input | 64 | Identifier field of an addressed request |
| req_crc_ok | input | 1 | Request CRC was good |
| sof_evt | input | 1 | One-cycle strobe: start-of-frame seen |
| eof_evt | input | 1 | One-cycle strobe: bare end-of-frame seen |
| pause_full | input | 1 | One-cycle strobe: full-depth pause seen |
| tx_start | output | 1 | One-cycle strobe: begin the reply |
| tx_kind | output | 1 | 0 = inventory reply, 1 = reset reply |
| tag_state | output | 2 | 0 Ready, 1 Quiet, 2 Held-Quiet |

## Verification
The hardest case to reach is the Held-Quiet hold boundary. It needs the field to stay absent across an exact number of slow ticks and then return. The bench drops `field_on` and issues single-cycle ticks one short of the limit, then restores the field. It repeats this with exactly the limit and reads `tag_state` after each. A later slot answer is also awkward to reach. To get one, the bench steps the slot counter with a known count of bare end-of-frame strobes and counts transmit pulses after each strobe. It also interleaves a start-of-frame to show that the sequence stops.

// File: rtl/tag_ctrl_pkg.sv
package tag_ctrl_pkg;
  typedef enum logic [1:0] {
    ST_READY  = 2'd0,
    ST_QUIET  = 2'd1,
    ST_HELDQ  = 2'd2
  } tag_state_e;

  localparam logic [7:0] CMD_INVENTORY = 8'h01;
  localparam logic [7:0] CMD_STAY_QUIET = 8'h02;
  localparam logic [7:0] CMD_RESET_RDY = 8'h26;
  localparam logic [7:0] CMD_HELD_QUIET = 8'hAA;

  localparam int FLG_INVENTORY = 2;
  localparam int FLG_EXTENSION = 3;
  localparam int FLG_SELECT_AFI = 4;
  localparam int FLG_ADDR_SLOTS = 5;
  localparam int FLG_RESERVED = 7;

  localparam logic KIND_INVENTORY = 1'b0;
  localparam logic KIND_RESET = 1'b1;
endpackage

// File: rtl/uid_slot_match.sv
module uid_slot_match #(
  parameter int ID_W = 64,
  parameter int LEN_W = 7,
  parameter int SN_W = 4
) (
  input  logic [ID_W-1:0]  own_id,
  input  logic [ID_W-1:0]  mask_bits,
  input  logic [LEN_W-1:0] mask_len,
  input  logic             single_slot,
  input  logic [SN_W-1:0]  slot_num,
  output logic             hit
);
  localparam int CW_W = LEN_W + 1;

  function automatic logic [ID_W-1:0] low_ones(input logic [CW_W-1:0] n);
    logic [ID_W-1:0] r;
    if (n >= CW_W'(ID_W)) r = '1;
    else r = (ID_W'(1) << n) - ID_W'(1);
    return r;
  endfunction

  logic [CW_W-1:0] cmp_w;
  logic [ID_W-1:0] slot_part;
  logic [ID_W-1:0] expect_v;

  always_comb begin
    cmp_w = single_slot ? CW_W'(mask_len) : CW_W'(mask_len) + CW_W'(SN_W);
    slot_part = single_slot ? '0 : (ID_W'(slot_num) << mask_len);
    expect_v = slot_part | (mask_bits & low_ones(CW_W'(mask_len)));
    hit = (((own_id ^ expect_v) & low_ones(cmp_w)) == '0);
  end
endmodule

// File: rtl/resp_delay_timer.sv
module resp_delay_timer #(
  parameter int RESP_DELAY = 4352
) (
  input  logic clk,
  input  logic rst_n,
  input  logic start,
  input  logic kind_in,
  input  logic restart,
  input  logic abort,
  output logic tx_start,
  output logic tx_kind
);
  localparam int CW = $clog2(RESP_DELAY + 1);

  logic [CW-1:0] cnt_q, cnt_d;
  logic busy_q, busy_d;
  logic kind_q, kind_d;
  logic fire_d;

  always_comb begin
    cnt_d = cnt_q;
    busy_d = busy_q;
    kind_d = kind_q;
    fire_d = 1'b0;
    if (start) begin
      cnt_d = '0;
      busy_d = 1'b1;
      kind_d = kind_in;
    end else if (abort) begin
      busy_d = 1'b0;
      cnt_d = '0;
    end else if (busy_q) begin
      if (restart) begin
        cnt_d = '0;
      end else if (cnt_q == CW'(RESP_DELAY - 1)) begin
        fire_d = 1'b1;
        busy_d = 1'b0;
        cnt_d = '0;
      end else begin
        cnt_d = cnt_q + CW'(1);
      end
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      cnt_q <= '0;
      busy_q <= 1'b0;
      kind_q <= 1'b0;
      tx_start <= 1'b0;
    end else begin
      cnt_q <= cnt_d;
      busy_q <= busy_d;
      kind_q <= kind_d;
      tx_start <= fire_d;
    end
  end

  assign tx_kind = kind_q;
endmodule

// File: rtl/hold_quiet_timer.sv
module hold_quiet_timer #(
  parameter int HOLD_TICKS = 1000
) (
  input  logic clk,
  input  logic rst_n,
  input  logic field_on,
  input  logic slow_tick,
  output logic expired
);
  localparam int HW = $clog2(HOLD_TICKS + 1);

  logic [HW-1:0] cnt_q, cnt_d;

  always_comb begin
    cnt_d = cnt_q;
    if (field_on) cnt_d = '0;
    else if (slow_tick && (cnt_q != HW'(HOLD_TICKS))) cnt_d = cnt_q + HW'(1);
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) cnt_q <= '0;
    else cnt_q <= cnt_d;
  end

  assign expired = !field_on && (cnt_q == HW'(HOLD_TICKS));
endmodule

// File: rtl/tag_inventory_ctrl.sv
module tag_inventory_ctrl
  import tag_ctrl_pkg::*;
#(
  parameter logic [63:0] OWN_UID = 64'hE016_0800_1234_5678,
  parameter int RESP_DELAY = 4352,
  parameter int HOLD_TICKS = 3000,
  parameter int SLOT_BITS = 4
) (
  input  logic        clk,
  input  logic        rst_n,
  input  logic        field_on,
  input  logic        slow_tick,
  input  logic        req_valid,
  input  logic [7:0]  req_flags,
  input  logic [7:0]  req_cmd,
  input  logic [6:0]  req_mask_len,
  input  logic [63:0] req_mask,
  input  logic [63:0] req_uid,
  input  logic        req_crc_ok,
  input  logic        sof_evt,
  input  logic        eof_evt,
  input  logic        pause_full,
  output logic        tx_start,
  output logic        tx_kind,
  output logic [1:0]  tag_state
);
  localparam int ID_W = 64;
  localparam int LEN_W = 7;
  localparam logic [SLOT_BITS-1:0] LAST_SLOT = '1;
  localparam logic [LEN_W-1:0] MAX_LEN_ONE = LEN_W'(ID_W);
  localparam logic [LEN_W-1:0] MAX_LEN_MANY = LEN_W'(ID_W - SLOT_BITS);

  tag_state_e state_q, state_d;
  logic inv_on_q, inv_on_d;
  logic [SLOT_BITS-1:0] sn_q, sn_d;
  logic [ID_W-1:0] mask_q, mask_d;
  logic [LEN_W-1:0] len_q, len_d;
  logic one_q, one_d;

  logic hold_expired;
  logic go, go_kind;
  logic m_hit;
  logic [ID_W-1:0] m_mask;
  logic [LEN_W-1:0] m_len;
  logic m_one;
  logic [SLOT_BITS-1:0] m_sn;

  logic req_ok, flags_bad, addr_flag, inv_flag, uid_hit, len_ok;
  logic step_eof;

  always_comb begin
    req_ok = req_valid && field_on;
    flags_bad = !req_crc_ok || req_flags[FLG_EXTENSION] ||
                req_flags[FLG_SELECT_AFI] || req_flags[FLG_RESERVED];
    addr_flag = req_flags[FLG_ADDR_SLOTS];
    inv_flag = req_flags[FLG_INVENTORY];
    uid_hit = (req_uid == OWN_UID);
    len_ok = addr_flag ? (req_mask_len <= MAX_LEN_ONE) : (req_mask_len <= MAX_LEN_MANY);
    step_eof = !req_valid && !sof_evt && eof_evt && field_on && inv_on_q;
  end

  // Matcher inputs: the live request for slot 0, stored values for later slots
  always_comb begin
    if (req_valid) begin
      m_mask = req_mask;
      m_len = req_mask_len;
      m_one = addr_flag;
      m_sn = '0;
    end else begin
      m_mask = mask_q;
      m_len = len_q;
      m_one = one_q;
      m_sn = sn_q + SLOT_BITS'(1);
    end
  end

  uid_slot_match #(
    .ID_W(ID_W),
    .LEN_W(LEN_W),
    .SN_W(SLOT_BITS)
  ) u_match (
    .own_id(OWN_UID),
    .mask_bits(m_mask),
    .mask_len(m_len),
    .single_slot(m_one),
    .slot_num(m_sn),
    .hit(m_hit)
  );

  hold_quiet_timer #(
    .HOLD_TICKS(HOLD_TICKS)
  ) u_hold (
    .clk(clk),
    .rst_n(rst_n),
    .field_on(field_on),
    .slow_tick(slow_tick),
    .expired(hold_expired)
  );

  // Next-state decision
  always_comb begin
    state_d = state_q;
    inv_on_d = inv_on_q;
    sn_d = sn_q;
    mask_d = mask_q;
    len_d = len_q;
    one_d = one_q;
    go = 1'b0;
    go_kind = KIND_INVENTORY;

    if (!field_on) begin
      inv_on_d = 1'b0;
      if (state_q == ST_QUIET) state_d = ST_READY;
      else if ((state_q == ST_HELDQ) && hold_expired) state_d = ST_READY;
    end else if (req_valid || sof_evt) begin
      inv_on_d = 1'b0;
    end

    if (req_ok && !flags_bad) begin
      if (inv_flag) begin
        if ((req_cmd == CMD_INVENTORY) && (state_q == ST_READY) && len_ok) begin
          inv_on_d = 1'b1;
          sn_d = '0;
          mask_d = req_mask;
          len_d = req_mask_len;
          one_d = addr_flag;
          go = m_hit;
          go_kind = KIND_INVENTORY;
        end
      end else begin
        unique case (req_cmd)
          CMD_STAY_QUIET: if (addr_flag && uid_hit) state_d = ST_QUIET;
          CMD_HELD_QUIET: if (addr_flag && uid_hit) state_d = ST_HELDQ;
          CMD_RESET_RDY: begin
            if (addr_flag) begin
              if (uid_hit) begin
                state_d = ST_READY;
                go = 1'b1;
                go_kind = KIND_RESET;
              end
            end else if (state_q != ST_QUIET) begin
              state_d = ST_READY;
              go = 1'b1;
              go_kind = KIND_RESET;
            end
          end
          default: ;
        endcase
      end
    end else if (step_eof) begin
      if (one_q || (sn_q == LAST_SLOT)) begin
        inv_on_d = 1'b0;
      end else begin
        sn_d = sn_q + SLOT_BITS'(1);
        go = m_hit;
        go_kind = KIND_INVENTORY;
      end
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      state_q <= ST_READY;
      inv_on_q <= 1'b0;
      sn_q <= '0;
      mask_q <= '0;
      len_q <= '0;
      one_q <= 1'b0;
    end else begin
      state_q <= state_d;
      inv_on_q <= inv_on_d;
      sn_q <= sn_d;
      if (req_ok) begin
        mask_q <= mask_d;
        len_q <= len_d;
        one_q <= one_d;
      end
    end
  end

  resp_delay_timer #(
    .RESP_DELAY(RESP_DELAY)
  ) u_timer (
    .clk(clk),
    .rst_n(rst_n),
    .start(go),
    .kind_in(go_kind),
    .restart(pause_full),
    .abort(!field_on || req_valid || sof_evt || (state_d != ST_READY)),
    .tx_start(tx_start),
    .tx_kind(tx_kind)
  );

  assign tag_state = state_q;
endmodule

// File: rtl/tag_inventory_ctrl_chk.sv
module tag_inventory_ctrl_chk (
  input logic       clk,
  input logic       rst_n,
  input logic       field_on,
  input logic       req_valid,
  input logic       req_crc_ok,
  input logic       tx_start,
  input logic [1:0] tag_state
);
  // R14
  tx_single_chk: assert property (@(posedge clk) disable iff (!rst_n)
    tx_start |=> !tx_start);

  // R14
  tx_ready_only_chk: assert property (@(posedge clk) disable iff (!rst_n)
    tx_start |-> (tag_state == 2'd0));

  // R14
  tx_no_field_chk: assert property (@(posedge clk) disable iff (!rst_n)
    !field_on |=> !tx_start);

  // R12
  quiet_drop_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (!field_on && tag_state == 2'd1) |=> (tag_state == 2'd0));

  // R5
  bad_crc_state_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (req_valid && !req_crc_ok && field_on) |=> $stable(tag_state));

  // R12
  state_code_chk: assert property (@(posedge clk) disable iff (!rst_n)
    tag_state != 2'd3);
endmodule

bind tag_inventory_ctrl tag_inventory_ctrl_chk u_chk (
  .clk(clk),
  .rst_n(rst_n),
  .field_on(field_on),
  .req_valid(req_valid),
  .req_crc_ok(req_crc_ok),
  .tx_start(tx_start),
  .tag_state(tag_state)
);

// File: tb/tag_inventory_ctrl_tb.sv
module tag_inventory_ctrl_tb;
  localparam logic [63:0] UID = 64'hE016_0000_C0FF_EE37;
  localparam int D = 40;
  localparam int HOLD = 5;

  logic clk, rst_n, field_on, slow_tick, req_valid, req_crc_ok;
  logic sof_evt, eof_evt, pause_full;
  logic [7:0] req_flags, req_cmd;
  logic [6:0] req_mask_len;
  logic [63:0] req_mask, req_uid;
  logic tx_start, tx_kind;
  logic [1:0] tag_state;
  int checks = 0;
  int fails = 0;
  bit done = 0;

  tag_inventory_ctrl #(
    .OWN_UID(UID), .RESP_DELAY(D), .HOLD_TICKS(HOLD), .SLOT_BITS(4)
  ) u_dut (
    .clk(clk), .rst_n(rst_n), .field_on(field_on), .slow_tick(slow_tick),
    .req_valid(req_valid), .req_flags(req_flags), .req_cmd(req_cmd),
    .req_mask_len(req_mask_len), .req_mask(req_mask), .req_uid(req_uid),
    .req_crc_ok(req_crc_ok), .sof_evt(sof_evt), .eof_evt(eof_evt),
    .pause_full(pause_full), .tx_start(tx_start), .tx_kind(tx_kind),
    .tag_state(tag_state)
  );

  initial clk = 1'b0;
  always #10 clk = ~clk;

  task automatic check(input bit ok, input string req, input int act, input int exp);
    checks++;
    if (!ok) begin
      fails++;
      $display("FAIL %s actual=%0d expected=%0d", req, act, exp);
    end
  endtask

  task automatic send_req(input logic [7:0] fl, input logic [7:0] cmd,
                          input logic [6:0] len, input logic [63:0] mk,
                          input logic [63:0] id, input logic crc);
    @(negedge clk);
    req_valid = 1; req_flags = fl; req_cmd = cmd; req_mask_len = len;
    req_mask = mk; req_uid = id; req_crc_ok = crc;
    @(negedge clk);
    req_valid = 0;
  endtask

  task automatic send_ev(input bit is_sof);
    @(negedge clk);
    if (is_sof) sof_evt = 1; else eof_evt = 1;
    @(negedge clk);
    sof_evt = 0; eof_evt = 0;
  endtask

  // Count tx pulses from the first negedge after the triggering edge.
  task automatic watch(input int exp_n, input logic exp_kind, input string req);
    int n = 0;
    int first = 0;
    logic kind = 1'b0;
    for (int k = 1; k <= D + 8; k++) begin
      if (tx_start) begin
        n++;
        if (first == 0) begin first = k; kind = tx_kind; end
      end
      if (k < D + 8) @(negedge clk);
    end
    check(n == exp_n, req, n, exp_n);
    if (exp_n > 0) begin
      check(first == D + 1, req, first, D + 1);
      check(kind == exp_kind, req, int'(kind), int'(exp_kind));
    end
  endtask

  task automatic t_reset();
    check(tag_state == 2'd0, "R9 reset state", tag_state, 0);
    check(tx_start == 1'b0, "R14 reset tx", tx_start, 0);
  endtask

  task automatic t_one_slot();
    send_req(8'h24, 8'h01, 7'd0, 64'd0, 64'd0, 1); watch(1, 0, "R1 one slot len0");
    send_req(8'h26, 8'h01, 7'd64, UID, 64'd0, 1); watch(1, 0, "R3 full mask");
    send_req(8'h24, 8'h01, 7'd8, 64'h36, 64'd0, 1); watch(0, 0, "R3 mask mismatch");
    send_req(8'h24, 8'h01, 7'd8, 64'h37, 64'd0, 1); watch(1, 0, "R3 mask match");
    send_ev(0); watch(0, 0, "R13 eof after single slot");
  endtask

  task automatic t_slots();
    // slot field = UID[3:0] = 7
    send_req(8'h04, 8'h01, 7'd0, 64'd0, 64'd0, 1); watch(0, 0, "R2 slot0 silent");
    for (int s = 1; s <= 7; s++) begin
      send_ev(0);
      watch((s == 7) ? 1 : 0, 0, "R2 slot step");
    end
    // mask 4 bits = 7, slot field = UID[7:4] = 3
    send_req(8'h04, 8'h01, 7'd4, 64'h7, 64'd0, 1); watch(0, 0, "R2 masked slot0");
    for (int s = 1; s <= 3; s++) begin
      send_ev(0);
      watch((s == 3) ? 1 : 0, 0, "R2 masked slot step");
    end
  endtask

  task automatic t_limits();
    send_req(8'h04, 8'h01, 7'd61, UID, 64'd0, 1); watch(0, 0, "R4 len 61 sixteen slots");
    send_req(8'h24, 8'h01, 7'd65, UID, 64'd0, 1); watch(0, 0, "R4 len 65 one slot");
  endtask

  task automatic t_rejects();
    send_req(8'h24, 8'h01, 7'd0, 0, 0, 0); watch(0, 0, "R5 bad crc");
    send_req(8'h34, 8'h01, 7'd0, 0, 0, 1); watch(0, 0, "R5 afi flag");
    send_req(8'h2C, 8'h01, 7'd0, 0, 0, 1); watch(0, 0, "R5 extension flag");
    send_req(8'hA4, 8'h01, 7'd0, 0, 0, 1); watch(0, 0, "R5 reserved flag");
    send_req(8'h20, 8'h02, 7'd0, 0, UID, 0);
    check(tag_state == 2'd0, "R5 bad crc stay quiet", tag_state, 0);
    send_req(8'h30, 8'h02, 7'd0, 0, UID, 1);
    check(tag_state == 2'd0, "R5 select flag stay quiet", tag_state, 0);
    send_req(8'h20, 8'h20, 7'd0, 0, UID, 1); watch(0, 0, "R6 unknown command");
  endtask

  task automatic t_quiet();
    send_req(8'h20, 8'h02, 7'd0, 0, UID ^ 64'h1, 1);
    check(tag_state == 2'd0, "R7 stay quiet other uid", tag_state, 0);
    send_req(8'h20, 8'h02, 7'd0, 0, UID, 1); watch(0, 0, "R7 stay quiet silent");
    check(tag_state == 2'd1, "R7 stay quiet state", tag_state, 1);
    send_req(8'h24, 8'h01, 7'd0, 0, 0, 1); watch(0, 0, "R8 inventory in quiet");
    send_req(8'h00, 8'h26, 7'd0, 0, 0, 1); watch(0, 0, "R9 broadcast reset in quiet");
    check(tag_state == 2'd1, "R9 quiet kept", tag_state, 1);
    send_req(8'h20, 8'h26, 7'd0, 0, UID, 1); watch(1, 1, "R9 addressed reset");
    check(tag_state == 2'd0, "R9 back to ready", tag_state, 0);
  endtask

  task automatic t_held();
    send_req(8'h20, 8'hAA, 7'd0, 0, UID, 1); watch(0, 0, "R10 held quiet silent");
    check(tag_state == 2'd2, "R10 held state", tag_state, 2);
    send_req(8'h24, 8'h01, 7'd0, 0, 0, 1); watch(0, 0, "R8 inventory in held");
    send_req(8'h00, 8'h26, 7'd0, 0, 0, 1); watch(1, 1, "R9 broadcast release");
    check(tag_state == 2'd0, "R9 released", tag_state, 0);
  endtask

  task automatic t_pause();
    send_req(8'h24, 8'h01, 7'd0, 0, 0, 1);
    repeat (9) @(negedge clk);
    pause_full = 1;
    @(negedge clk);
    pause_full = 0;
    watch(1, 0, "R11 pause restart");
  endtask

  task automatic t_sof();
    send_req(8'h04, 8'h01, 7'd0, 0, 0, 1); watch(0, 0, "R13 seq slot0");
    send_ev(0); send_ev(0); send_ev(0);
    send_ev(1);
    send_ev(0); send_ev(0); send_ev(0);
    send_ev(0); watch(0, 0, "R13 eof after sof");
  endtask

  task automatic t_field();
    send_req(8'h20, 8'h02, 7'd0, 0, UID, 1);
    @(negedge clk); field_on = 0;
    @(negedge clk);
    check(tag_state == 2'd0, "R12 quiet lost with field", tag_state, 0);
    field_on = 1;
    send_req(8'h20, 8'hAA, 7'd0, 0, UID, 1);
    @(negedge clk); field_on = 0;
    for (int i = 0; i < HOLD - 1; i++) begin
      slow_tick = 1; @(negedge clk); slow_tick = 0; @(negedge clk);
    end
    field_on = 1; @(negedge clk); @(negedge clk);
    check(tag_state == 2'd2, "R12 held survives short loss", tag_state, 2);
    field_on = 0;
    for (int i = 0; i < HOLD; i++) begin
      slow_tick = 1; @(negedge clk); slow_tick = 0; @(negedge clk);
    end
    @(negedge clk);
    check(tag_state == 2'd0, "R12 held expires", tag_state, 0);
    field_on = 1;
    send_req(8'h24, 8'h01, 7'd0, 0, 0, 1);
    repeat (4) @(negedge clk);
    field_on = 0; @(negedge clk); field_on = 1;
    watch(0, 0, "R14 field loss cancels reply");
  endtask

  initial begin
    rst_n = 0; field_on = 1; slow_tick = 0; req_valid = 0; req_flags = 0;
    req_cmd = 0; req_mask_len = 0; req_mask = 0; req_uid = 0; req_crc_ok = 0;
    sof_evt = 0; eof_evt = 0; pause_full = 0;
    repeat (3) @(negedge clk);
    rst_n = 1;
    @(negedge clk);
    t_reset();
    t_one_slot();
    t_slots();
    t_limits();
    t_rejects();
    t_quiet();
    t_held();
    t_pause();
    t_sof();
    t_field();
    done = 1;
  end

  initial begin
    fork
      begin wait (done); end
      begin
        repeat (150000) @(posedge clk);
        checks++; fails++;
        $display("FAIL watchdog actual=%0d expected=%0d", 0, 1);
      end
    join_any
    $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
    $finish;
  end
endmodule